// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor core. It completes each instruction in one clock cycle. On every cycle the program counter drives the instruction port. The fetched word is decoded in the same cycle, and the core reads its register file, computes through its ALU and, where needed, reads or writes the data port. The register file, the data memory, the program counter and the exception PC all update on the next rising edge. A write made by one instruction is therefore visible to the instruction that follows it.

The core runs a fixed set of ten instructions: load word, store word, add, subtract, and, or, nor, set-less-than, branch-if-equal and an absolute jump. It has no stall, no handshake and no cache. The instruction memory is read combinationally, and the data memory is read combinationally and written on the clock edge. These memories live outside the core. Two conditions trap: an opcode or function code outside the supported set, and signed overflow on add or subtract. A trap suppresses every state write of the faulting instruction except the saved PC, and it redirects fetch to a fixed handler address.

The next-PC selection works as a small state choice made each cycle. The four selections are sequential (PC+4), branch, jump and trap. Trap has the highest priority, then jump, then a taken branch, and sequential is the default.

Top module: `sc_core`

## Requirements
- R1: With `rst` high at a rising edge, the core sets the PC to 0x00000000 and clears `epc` to zero. While `rst` is high, it raises no data write.
- R2: An instruction that does not branch, jump or trap advances the PC by 4 on the next edge.
- R3: An R-type instruction has opcode 0 in bits 31-26, sources in bits 25-21 and 20-16, destination in bits 15-11 and function code in bits 5-0. The function codes are add=32, sub=34, and=36, or=37, nor=39 and slt=42. Set-less-than compares as signed and writes 1 or 0.
- R4: Load word (opcode 100011) and store word (opcode 101011) form the address as the register in bits 25-21 plus the sign-extended bits 15-0. A load writes the read data to the register in bits 20-16. A store writes that register to memory and writes no register.
- R5: Branch-if-equal (opcode 000100) moves to PC+4 plus the sign-extended offset shifted left by two when its two registers are equal. Otherwise it moves to PC+4.
- R6: Jump (opcode 000010) moves to the top four bits of PC+4, followed by bits 25-0 of the instruction, followed by two zero bits.
- R7: Register 0 always reads as zero, and a write to it leaves it zero.
- R8: Signed overflow on add or sub raises `exc_ovf` for that cycle, and the destination register keeps its old value.
- R9: An unsupported opcode, or an R-type function code outside the six listed, raises `exc_illegal`. No other instruction raises it, and `exc_illegal` and `exc_ovf` are never high together.
- R10: On either exception, the core blocks the data write. On the next edge the PC becomes 0x80000180 and `epc` takes the PC of the faulting instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Current PC, the instruction fetch address |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data address, the ALU result |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| dmem_we | output | 1 | Store enable, written at the next edge |
| dmem_re | output | 1 | Load strobe |
| exc_illegal | output | 1 | Current instruction is not supported |
| exc_ovf | output | 1 | Current add or sub overflows |
| epc | output | 32 | PC of the most recent faulting instruction |

## Verification
The hardest thing to show from the ports is that a trapped instruction left no trace. A suppressed register write only becomes visible if a later instruction stores that register. The test program therefore overflows into a chosen register, and the trap handler then stores that same register, which must still hold zero. The handler itself jumps within the high address region and then hits an undefined opcode. This checks the upper PC bits of the jump and makes a second trap fire while `epc` already holds a value. Separate reset phases cover overflow on subtract and an unsupported function code.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_J     = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_NOR = 6'd39;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        CLS_ARITH, CLS_LOAD, CLS_STORE, CLS_BRANCH, CLS_JUMP, CLS_BAD
    } instr_cls_e;

    typedef enum logic [1:0] {
        AOP_ADD = 2'b00, AOP_SUB = 2'b01, AOP_FUNCT = 2'b10
    } alu_sel_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT
    } alu_fn_e;

    typedef enum logic [1:0] {
        PCS_SEQ, PCS_BRANCH, PCS_JUMP, PCS_TRAP
    } pc_sel_e;

    typedef struct packed {
        logic    dst_rd;
        logic    src_imm;
        logic    load_wb;
        logic    reg_we;
        logic    mem_rd;
        logic    mem_wr;
        logic    branch;
        logic    jump;
        alu_fn_e alu_fn;
        logic    bad;
        logic    ovf_chk;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    instr_cls_e cls;
    alu_sel_e   aop;
    ctrl_t      main_c;
    alu_fn_e    fn;
    logic       fn_ok;

    always_comb begin
        unique case (opcode)
            OP_RTYPE: cls = CLS_ARITH;
            OP_LW:    cls = CLS_LOAD;
            OP_SW:    cls = CLS_STORE;
            OP_BEQ:   cls = CLS_BRANCH;
            OP_J:     cls = CLS_JUMP;
            default:  cls = CLS_BAD;
        endcase
    end

    // main control table; don't-care entries tied low
    always_comb begin
        main_c        = '0;
        main_c.alu_fn = ALU_ADD;
        aop           = AOP_ADD;
        unique case (cls)
            CLS_ARITH: begin
                main_c.dst_rd = 1'b1;
                main_c.reg_we = 1'b1;
                aop           = AOP_FUNCT;
            end
            CLS_LOAD: begin
                main_c.src_imm = 1'b1;
                main_c.load_wb = 1'b1;
                main_c.reg_we  = 1'b1;
                main_c.mem_rd  = 1'b1;
            end
            CLS_STORE: begin
                main_c.src_imm = 1'b1;
                main_c.mem_wr  = 1'b1;
            end
            CLS_BRANCH: begin
                main_c.branch = 1'b1;
                aop           = AOP_SUB;
            end
            CLS_JUMP: main_c.jump = 1'b1;
            default:  main_c.bad  = 1'b1;
        endcase
    end

    // ALU control from the two-bit selector and the function code
    always_comb begin
        fn_ok = 1'b1;
        unique case (aop)
            AOP_ADD: fn = ALU_ADD;
            AOP_SUB: fn = ALU_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_ADD: fn = ALU_ADD;
                    FN_SUB: fn = ALU_SUB;
                    FN_AND: fn = ALU_AND;
                    FN_OR:  fn = ALU_OR;
                    FN_NOR: fn = ALU_NOR;
                    FN_SLT: fn = ALU_SLT;
                    default: begin
                        fn    = ALU_ADD;
                        fn_ok = 1'b0;
                    end
                endcase
            end
            default: fn = ALU_ADD;
        endcase
    end

    always_comb begin
        ctrl         = main_c;
        ctrl.alu_fn  = fn;
        ctrl.bad     = main_c.bad | ((cls == CLS_ARITH) & ~fn_ok);
        ctrl.ovf_chk = (cls == CLS_ARITH) && (funct == FN_ADD || funct == FN_SUB);
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         ovf
);
    logic [W-1:0] sum, diff;

    assign sum  = a + b;
    assign diff = a - b;

    always_comb begin
        unique case (fn)
            ALU_ADD: y = sum;
            ALU_SUB: y = diff;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = sum;
        endcase
    end

    always_comb begin
        unique case (fn)
            ALU_ADD: ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            ALU_SUB: ovf = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
            default: ovf = 1'b0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] TRAP_VEC = 32'h8000_0180
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata,
    output logic        dmem_we,
    output logic        dmem_re,
    output logic        exc_illegal,
    output logic        exc_ovf,
    output logic [31:0] epc
);
    localparam int NREG = 1 << RIDX_W;

    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target, imm_ext;
    logic [XLEN-1:0]   rd_a, rd_b, alu_b, alu_y, wb_data;
    logic [XLEN-1:0]   epc_q;
    logic [RIDX_W-1:0] rs, rt, rd, waddr;
    logic              zero, ovf_raw, trap;
    ctrl_t             ctrl;
    pc_sel_e           pc_sel;

    assign rs      = imem_data[25:21];
    assign rt      = imem_data[20:16];
    assign rd      = imem_data[15:11];
    assign imm_ext = {{16{imem_data[15]}}, imem_data[15:0]};

    sc_decode u_dec (
        .opcode (imem_data[31:26]),
        .funct  (imem_data[5:0]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk     (clk),
        .we      (ctrl.reg_we & ~trap & ~rst),
        .waddr   (waddr),
        .wdata   (wb_data),
        .raddr_a (rs),
        .raddr_b (rt),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rd_b;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rd_a),
        .b    (alu_b),
        .fn   (ctrl.alu_fn),
        .y    (alu_y),
        .zero (zero),
        .ovf  (ovf_raw)
    );

    assign waddr   = ctrl.dst_rd ? rd : rt;
    assign wb_data = ctrl.load_wb ? dmem_rdata : alu_y;

    assign exc_illegal = ctrl.bad;
    assign exc_ovf     = ctrl.ovf_chk & ovf_raw;
    assign trap        = exc_illegal | exc_ovf;

    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};

    // next-PC selection, trap first
    always_comb begin
        if (trap)                      pc_sel = PCS_TRAP;
        else if (ctrl.jump)            pc_sel = PCS_JUMP;
        else if (ctrl.branch && zero)  pc_sel = PCS_BRANCH;
        else                           pc_sel = PCS_SEQ;
    end

    always_comb begin
        unique case (pc_sel)
            PCS_SEQ:    pc_next = pc_plus4;
            PCS_BRANCH: pc_next = br_target;
            PCS_JUMP:   pc_next = {pc_plus4[31:28], imem_data[25:0], 2'b00};
            PCS_TRAP:   pc_next = TRAP_VEC;
            default:    pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_PC;
            epc_q <= '0;
        end else begin
            pc_q <= pc_next;
            if (pc_sel == PCS_TRAP) epc_q <= pc_q;
        end
    end

    assign imem_addr  = pc_q;
    assign epc        = epc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rd_b;
    assign dmem_we    = ctrl.mem_wr & ~trap & ~rst;
    assign dmem_re    = ctrl.mem_rd & ~trap;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] TRAP_VEC = 32'h8000_0180
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic        dmem_we,
    input logic        exc_illegal,
    input logic        exc_ovf,
    input logic [31:0] epc
);
    logic [31:0] pc_inc;
    logic        exc_any, is_flow;

    assign pc_inc  = imem_addr + 32'd4;
    assign exc_any = exc_illegal | exc_ovf;
    assign is_flow = (imem_data[31:26] == 6'b000100) || (imem_data[31:26] == 6'b000010);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (imem_addr == RESET_PC && epc == 32'd0));

    p_reset_no_store_r1: assert property (@(posedge clk)
        rst |-> !dmem_we);

    p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (!is_flow && !exc_any) |=> (imem_addr == $past(pc_inc)));

    p_jump_target_r6: assert property (@(posedge clk) disable iff (rst)
        (imem_data[31:26] == 6'b000010 && !exc_any)
        |=> (imem_addr == {$past(pc_inc[31:28]), $past(imem_data[25:0]), 2'b00}));

    p_exc_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exc_illegal, exc_ovf}));

    p_no_store_on_trap_r10: assert property (@(posedge clk) disable iff (rst)
        exc_any |-> !dmem_we);

    p_trap_redirect_r10: assert property (@(posedge clk) disable iff (rst)
        exc_any |=> (imem_addr == TRAP_VEC && epc == $past(imem_addr)));

    p_epc_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !exc_any |=> $stable(epc));
endmodule

bind sc_core sc_core_chk #(.RESET_PC(RESET_PC), .TRAP_VEC(TRAP_VEC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .imem_addr   (imem_addr),
    .imem_data   (imem_data),
    .dmem_we     (dmem_we),
    .exc_illegal (exc_illegal),
    .exc_ovf     (exc_ovf),
    .epc         (epc)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, epc;
    logic        dmem_we, dmem_re, exc_illegal, exc_ovf;

    always #2 clk = ~clk;

    sc_core u0 (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_re(dmem_re),
        .exc_illegal(exc_illegal), .exc_ovf(exc_ovf), .epc(epc)
    );

    logic [31:0] imem [128];
    logic [31:0] dmem [64];

    assign imem_data  = imem[imem_addr[8:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    typedef struct {
        logic [31:0] pc;
        logic        ill;
        logic        ovf;
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] epc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   active = 1'b0;
    bit   done   = 1'b0;

    localparam logic [31:0] HV = 32'h8000_0180;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'b000010, tgt};
    endfunction

    task automatic push(input logic [31:0] pc, input logic ill, input logic ovf, input logic we,
                        input logic [31:0] addr, input logic [31:0] data, input logic [31:0] e_epc,
                        input string tag);
        exp_t e;
        e.pc = pc; e.ill = ill; e.ovf = ovf; e.we = we;
        e.addr = addr; e.data = data; e.epc = e_epc; e.tag = tag;
        exp_q.push_back(e);
    endtask
    task automatic step(input logic [31:0] pc, input logic [31:0] e_epc, input string tag);
        push(pc, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, e_epc, tag);
    endtask
    task automatic st(input logic [31:0] pc, input logic [31:0] a, input logic [31:0] d,
                      input logic [31:0] e_epc, input string tag);
        push(pc, 1'b0, 1'b0, 1'b1, a, d, e_epc, tag);
    endtask
    task automatic ex(input logic [31:0] pc, input logic ill, input logic ovf,
                      input logic [31:0] e_epc, input string tag);
        push(pc, ill, ovf, 1'b0, 32'd0, 32'd0, e_epc, tag);
    endtask

    // monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        exp_t e;
        bit   ok;
        if (active && exp_q.size() > 0) begin
            e  = exp_q.pop_front();
            ok = (imem_addr == e.pc) && (exc_illegal == e.ill) && (exc_ovf == e.ovf) &&
                 (dmem_we == e.we) && (epc == e.epc) &&
                 (!e.we || (dmem_addr == e.addr && dmem_wdata == e.data));
            checks++;
            if (!ok) begin
                fails++;
                $display("FAIL %s: got pc=%h ill=%b ovf=%b we=%b addr=%h data=%h epc=%h, expected pc=%h ill=%b ovf=%b we=%b addr=%h data=%h epc=%h",
                         e.tag, imem_addr, exc_illegal, exc_ovf, dmem_we, dmem_addr, dmem_wdata, epc,
                         e.pc, e.ill, e.ovf, e.we, e.addr, e.data, e.epc);
            end
        end
    end

    task automatic clear_imem();
        for (int i = 0; i < 128; i++) imem[i] = 32'd0;
        imem[96] = enc_i(6'b101011, 0, 12, 16'd56);   // store r12
        imem[97] = enc_j(26'd99);                     // jump inside high region
        imem[98] = enc_i(6'b101011, 0, 2, 16'd60);    // must be skipped
        imem[99] = 32'hFC00_0000;                     // undefined opcode
    endtask

    task automatic do_reset();
        active = 1'b0;
        rst    = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        checks++;
        if (imem_addr !== 32'd0 || epc !== 32'd0 || dmem_we !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got pc=%h epc=%h we=%b, expected pc=00000000 epc=00000000 we=0",
                     imem_addr, epc, dmem_we);
        end
    endtask

    task automatic run_phase();
        rst    = 1'b0;
        active = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk);
        #1 active = 1'b0;
        rst = 1'b1;
    endtask

    task automatic handler_tail(input logic [31:0] e_epc);
        st(HV, 32'd56, 32'd0, e_epc, "R8 handler store shows suppressed write");
        step(HV + 32'd4, e_epc, "R6 jump keeps upper PC bits");
        ex(HV + 32'd12, 1'b1, 1'b0, e_epc, "R9 undefined opcode");
        st(HV, 32'd56, 32'd0, HV + 32'd12, "R10 second trap updates epc");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) dmem[i] = 32'd0;
        dmem[0]  = 32'h7FFF_FFFF;
        dmem[1]  = 32'd5;
        dmem[2]  = 32'h8000_0000;
        dmem[63] = 32'h0000_1234;

        // phase A: main program ending in add overflow
        clear_imem();
        imem[0]  = enc_i(6'b100011, 0, 1, 16'd0);
        imem[1]  = enc_i(6'b100011, 0, 2, 16'd4);
        imem[2]  = enc_r(2, 2, 3, 6'd32);
        imem[3]  = enc_r(2, 3, 4, 6'd34);
        imem[4]  = enc_r(1, 4, 5, 6'd36);
        imem[5]  = enc_r(2, 3, 6, 6'd37);
        imem[6]  = enc_r(2, 0, 7, 6'd39);
        imem[7]  = enc_r(4, 2, 8, 6'd42);
        imem[8]  = enc_r(2, 4, 9, 6'd42);
        for (int k = 0; k < 7; k++) imem[9+k] = enc_i(6'b101011, 0, 3 + k, 16'(16 + 4*k));
        imem[16] = enc_r(2, 2, 0, 6'd32);
        imem[17] = enc_i(6'b101011, 0, 0, 16'd44);
        imem[18] = enc_i(6'b100011, 0, 10, 16'hFFFC);
        imem[19] = enc_i(6'b101011, 0, 10, 16'd48);
        imem[20] = enc_i(6'b000100, 2, 3, 16'd5);
        imem[21] = enc_i(6'b000100, 2, 2, 16'd2);
        imem[22] = enc_i(6'b101011, 0, 2, 16'd52);
        imem[23] = enc_i(6'b101011, 0, 2, 16'd52);
        imem[24] = enc_j(26'd27);
        imem[25] = enc_i(6'b101011, 0, 2, 16'd52);
        imem[26] = enc_i(6'b101011, 0, 2, 16'd52);
        imem[27] = enc_r(1, 1, 12, 6'd32);

        do_reset();
        for (int k = 0; k < 9; k++) step(32'(4*k), 32'd0, "R2 sequential fetch");
        st(32'd36, 32'd16, 32'd10,         32'd0, "R3 add result");
        st(32'd40, 32'd20, 32'hFFFF_FFFB,  32'd0, "R3 sub result");
        st(32'd44, 32'd24, 32'h7FFF_FFFB,  32'd0, "R3 and result");
        st(32'd48, 32'd28, 32'd15,         32'd0, "R3 or result");
        st(32'd52, 32'd32, 32'hFFFF_FFFA,  32'd0, "R3 nor result");
        st(32'd56, 32'd36, 32'd1,          32'd0, "R3 slt signed true");
        st(32'd60, 32'd40, 32'd0,          32'd0, "R3 slt signed false");
        step(32'd64, 32'd0, "R7 write to r0");
        st(32'd68, 32'd44, 32'd0,          32'd0, "R7 r0 reads zero");
        step(32'd72, 32'd0, "R4 load negative offset");
        st(32'd76, 32'd48, 32'h0000_1234,  32'd0, "R4 load via sign-extended offset");
        step(32'd80, 32'd0, "R5 beq not taken");
        step(32'd84, 32'd0, "R5 beq not taken goes to PC+4");
        step(32'd96, 32'd0, "R5 beq taken target");
        ex(32'd108, 1'b0, 1'b1, 32'd0, "R6 jump target / R8 add overflow");
        handler_tail(32'd108);
        run_phase();

        // phase B: subtract overflow
        clear_imem();
        imem[0] = enc_i(6'b100011, 0, 1, 16'd0);
        imem[1] = enc_i(6'b100011, 0, 2, 16'd8);
        imem[2] = enc_r(2, 1, 3, 6'd34);
        do_reset();
        step(32'd0, 32'd0, "R1 epc cleared after reset");
        step(32'd4, 32'd0, "R2 sequential fetch");
        ex(32'd8, 1'b0, 1'b1, 32'd0, "R8 sub overflow");
        handler_tail(32'd8);
        run_phase();

        // phase C: unsupported function code
        clear_imem();
        imem[0] = enc_r(0, 0, 5, 6'd33);
        do_reset();
        ex(32'd0, 1'b1, 1'b0, 32'd0, "R9 unsupported funct");
        handler_tail(32'd0);
        run_phase();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-run: got unfinished run, expected completion");
            summary();
            $finish;
        end
    end
endmodule